// File: doc/BRIEF.md
# Data-Strobe Serial Line Codec

This block codes a serial bit stream onto two wires, a data line and a strobe line, and decodes it again at the far end. The pair takes the place of a data line with a separate clock line. For every bit the transmitter accepts, exactly one of the two wires changes level. Each wire therefore changes at most once per bit time, and changes on the two wires fall a whole bit time apart. A receiver clocked at the bit rate can recover every bit, with no clock running at twice that rate.

The transmitter has two modes. In raw mode the data wire holds the bit value itself, and the strobe wire flips whenever the data wire keeps its level. In transition mode the bit chooses the wire: a 1 flips the data wire and a 0 flips the strobe wire. A DC-balanced code stream therefore stays balanced on both wires. The transmitter can also send an alternating 1/0 preamble so that a receiver can lock. The receiver passes both wires through synchronizers and reports a bit each time the parity of the two levels changes.

Top module: `ds_link_codec`

## Requirements
- R1: During and just after reset, tx_d, tx_s and rx_valid are low.
- R2: A clock edge with tx_en high flips exactly one of tx_d and tx_s. With tx_en low, both lines hold whatever tx_bit does.
- R3: In raw mode (mode=0), after each enabled bit tx_d equals the bit sent. tx_s flips only when that bit equals the previous tx_d.
- R4: In transition mode (mode=1), a bit of 1 flips tx_d and a bit of 0 flips tx_s.
- R5: In transition mode, from reset (both lines low), the bits 1010101010 give tx_d = 1100110011 and tx_s = 0110011001, first bit leftmost.
- R6: When tx_pre is high with tx_en, the bit sent ignores tx_bit and alternates 1,0,1,... A run of preamble bits always starts with 1, after reset or after any non-preamble bit.
- R7: rx_valid pulses high for one cycle per received bit. It rises on the third rising edge after the edge that changed a line.
- R8: In raw mode, rx_bit equals the received data-line level.
- R9: In transition mode, rx_bit is 1 when the data line changed and 0 when the strobe line changed.
- R10: With the lines looped back, bits sent back to back at one per clock, or with idle gaps between them, are recovered in order with none lost or added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bit time per cycle |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | 0 raw, 1 transition; shared by both directions |
| tx_en | input | 1 | Send one bit on this edge |
| tx_bit | input | 1 | Bit to send |
| tx_pre | input | 1 | Send the next preamble bit in place of tx_bit |
| tx_d | output | 1 | Transmit data line |
| tx_s | output | 1 | Transmit strobe line |
| rx_d | input | 1 | Receive data line, asynchronous |
| rx_s | input | 1 | Receive strobe line, asynchronous |
| rx_bit | output | 1 | Recovered bit |
| rx_valid | output | 1 | One-cycle strobe for rx_bit |

## Verification
The hardest case is a run of bits at full rate in which the same wire must flip again and again, or in which the wires alternate. This happens for repeated equal bits in raw mode and for the 1010 pattern in transition mode. Any slip in edge detection there drops or duplicates a bit. The bench loops the lines back and sends back-to-back runs of repeated bits, alternating bits and pseudo-random bits in both modes, with preamble runs and idle gaps between runs. A scoreboard checks that every recovered bit arrives in order.

// File: rtl/ds_pkg.sv
`timescale 1ns/1ps
package ds_pkg;
  typedef enum logic {
    MODE_RAW   = 1'b0,
    MODE_TRANS = 1'b1
  } ds_mode_e;
endpackage

// File: rtl/ds_sync.sv
`timescale 1ns/1ps
module ds_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/ds_tx.sv
`timescale 1ns/1ps
module ds_tx
  import ds_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  ds_mode_e mode,
  input  logic     tx_en,
  input  logic     tx_bit,
  input  logic     tx_pre,
  output logic     line_d,
  output logic     line_s
);
  logic d_q, s_q, pre_ph;
  logic b;

  // bit actually put on the wire
  assign b = tx_pre ? pre_ph : tx_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      d_q    <= 1'b0;
      s_q    <= 1'b0;
      pre_ph <= 1'b1;
    end else if (tx_en) begin
      pre_ph <= tx_pre ? ~pre_ph : 1'b1;
      if (mode == MODE_RAW) begin
        if (b != d_q) d_q <= b;
        else          s_q <= ~s_q;
      end else begin
        if (b) d_q <= ~d_q;
        else   s_q <= ~s_q;
      end
    end
  end

  assign line_d = d_q;
  assign line_s = s_q;

  // R2: one and only one wire moves per enabled bit
  p_one_toggle_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(tx_en)) |-> ((d_q != $past(d_q)) != (s_q != $past(s_q))));

  // R2: idle cycles leave both wires alone
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(tx_en)) |-> ($stable(d_q) && $stable(s_q)));

  // R3: raw mode puts the level of the data bit on the data wire
  p_raw_level_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(tx_en && !tx_pre && mode == MODE_RAW)) |-> (d_q == $past(tx_bit)));

  // R4: transition mode flips the data wire exactly for ones
  p_trans_pick_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(tx_en && !tx_pre && mode == MODE_TRANS)) |-> ((d_q != $past(d_q)) == $past(tx_bit)));
endmodule

// File: rtl/ds_rx.sv
`timescale 1ns/1ps
module ds_rx
  import ds_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  ds_mode_e mode,
  input  logic     sd,
  input  logic     ss,
  output logic     rx_bit,
  output logic     rx_valid
);
  logic d_q, s_q, bit_q, val_q;
  logic edge_seen;

  assign edge_seen = (sd ^ ss) != (d_q ^ s_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      d_q   <= 1'b0;
      s_q   <= 1'b0;
      bit_q <= 1'b0;
      val_q <= 1'b0;
    end else begin
      d_q   <= sd;
      s_q   <= ss;
      val_q <= edge_seen;
      if (mode == MODE_RAW) bit_q <= sd;
      else                  bit_q <= (sd != d_q);
    end
  end

  assign rx_bit   = bit_q;
  assign rx_valid = val_q;

  // R7: a strobe is never held across two cycles unless a second change arrived
  p_valid_from_edge_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && val_q) |-> $past(edge_seen));
endmodule

// File: rtl/ds_link_codec.sv
`timescale 1ns/1ps
module ds_link_codec
  import ds_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mode,
  input  logic tx_en,
  input  logic tx_bit,
  input  logic tx_pre,
  output logic tx_d,
  output logic tx_s,
  input  logic rx_d,
  input  logic rx_s,
  output logic rx_bit,
  output logic rx_valid
);
  localparam int LINES = 2;

  ds_mode_e   m;
  logic [LINES-1:0] raw_in, synced;

  assign m      = ds_mode_e'(mode);
  assign raw_in = {rx_d, rx_s};

  ds_tx u_tx (
    .clk(clk), .rst(rst), .mode(m), .tx_en(tx_en), .tx_bit(tx_bit),
    .tx_pre(tx_pre), .line_d(tx_d), .line_s(tx_s)
  );

  ds_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(raw_in), .dout(synced)
  );

  ds_rx u_rx (
    .clk(clk), .rst(rst), .mode(m), .sd(synced[1]), .ss(synced[0]),
    .rx_bit(rx_bit), .rx_valid(rx_valid)
  );

  // R1: nothing is reported in the first cycle out of reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!tx_d && !tx_s && !rx_valid));
endmodule

// File: tb/test_ds_link_codec.sv
`timescale 1ns/1ps
module test_ds_link_codec;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode = 1'b0, tx_en = 1'b0, tx_bit = 1'b0, tx_pre = 1'b0;
  logic tx_d, tx_s, rx_bit, rx_valid;

  int total = 0;
  int bad = 0;

  logic md = 1'b0, ms = 1'b0, mpre = 1'b1;
  logic [1:0] q[$];

  always #4 clk = ~clk;

  ds_link_codec i_ds_link_codec (
    .clk(clk), .rst(rst), .mode(mode), .tx_en(tx_en), .tx_bit(tx_bit),
    .tx_pre(tx_pre), .tx_d(tx_d), .tx_s(tx_s), .rx_d(tx_d), .rx_s(tx_s),
    .rx_bit(rx_bit), .rx_valid(rx_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: one bit per call, back to back when called in succession
  task automatic send(input logic b_in, input logic pre);
    logic b;
    @(negedge clk);
    tx_en = 1'b1; tx_bit = b_in; tx_pre = pre;
    b = pre ? mpre : b_in;
    if (pre) chk(b == mpre, "R6 preamble", b, mpre);
    mpre = pre ? ~mpre : 1'b1;
    if (mode == 1'b0) begin
      if (b != md) md = b; else ms = ~ms;
    end else begin
      if (b) md = ~md; else ms = ~ms;
    end
    q.push_back({pre, b});
    @(posedge clk);
    #2;
    tx_en = 1'b0;
    chk({tx_d, tx_s} == {md, ms}, mode ? "R4 lines" : "R3 lines", {tx_d, tx_s}, {md, ms});
  endtask

  task automatic drain();
    repeat (6) @(negedge clk);
  endtask

  // monitor: compare each recovered bit against the queue
  always @(negedge clk) begin
    if (!rst && rx_valid) begin
      if (q.size() == 0) begin
        chk(1'b0, "R10 extra bit", rx_bit, 0);
      end else begin
        logic [1:0] e;
        e = q.pop_front();
        chk(rx_bit == e[0], e[1] ? "R6 rx" : (mode ? "R9 rx" : "R8 rx"), rx_bit, e[0]);
      end
    end
  end

  initial begin
    #(8 * 200000);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [9:0] dseq, sseq;
    logic [7:0] lfsr;
    int first;
    repeat (3) @(posedge clk);
    #2;
    chk({tx_d, tx_s, rx_valid} == 3'b000, "R1 in reset", {tx_d, tx_s, rx_valid}, 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #2;
    chk({tx_d, tx_s, rx_valid} == 3'b000, "R1 after reset", {tx_d, tx_s, rx_valid}, 0);

    // R5 reference pattern in transition mode
    mode = 1'b1;
    for (int i = 0; i < 10; i++) begin
      send(~i[0], 1'b0);
      dseq[9-i] = tx_d; sseq[9-i] = tx_s;
    end
    chk(dseq == 10'b1100110011, "R5 data line", dseq, 10'b1100110011);
    chk(sseq == 10'b0110011001, "R5 strobe line", sseq, 10'b0110011001);
    drain();

    // R2 idle: tx_bit wiggles while disabled
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); tx_bit = ~tx_bit; tx_pre = i[0];
      @(posedge clk); #2;
      chk({tx_d, tx_s} == {md, ms}, "R2 idle hold", {tx_d, tx_s}, {md, ms});
    end
    drain();
    chk(q.size() == 0, "R2 no idle bits", q.size(), 0);

    // R3/R8 raw mode with repeats, back to back (R10)
    mode = 1'b0;
    begin
      logic [9:0] pat = 10'b0011101001;
      for (int i = 9; i >= 0; i--) send(pat[i], 1'b0);
    end
    drain();

    // R7 latency of a lone bit
    send(1'b1, 1'b0);
    first = 0;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (rx_valid && first == 0) first = i;
    end
    chk(first == 4, "R7 latency", first, 4);

    // R10 gapped bits in raw mode
    for (int i = 0; i < 6; i++) begin
      send(i[1], 1'b0);
      repeat (i) @(negedge clk);
    end
    drain();

    // R6 preamble then data, both modes
    for (int m = 0; m < 2; m++) begin
      mode = m[0];
      for (int i = 0; i < 6; i++) send(1'b0, 1'b1);
      send(1'b1, 1'b0); send(1'b1, 1'b0);
      for (int i = 0; i < 3; i++) send(1'b1, 1'b1);
      drain();
    end

    // R9/R10 pseudo-random stream in transition mode
    mode = 1'b1;
    lfsr = 8'hA5;
    for (int i = 0; i < 40; i++) begin
      send(lfsr[0], 1'b0);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end
    drain();
    chk(q.size() == 0, "R10 all recovered", q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule